// File: doc/BRIEF.md
# Coprocessor Execute Pipeline with Token-Gated Retirement

This block is the execute section of a tightly coupled coprocessor. Decoded instructions enter a six-deep in-order pipeline whose stages each hold an instruction word, a tag, a class and an occupancy bit. The core controls the fate of each instruction through three token queues that it fills: a kill queue, a completion queue and a load-data queue. Each queue is a small FIFO inside the block. A token is consumed only when the instruction it names is removed.

An instruction in the first stage is discarded when the head of the kill queue carries its tag. A store never goes deeper than the first stage. It retires on the cycle it leaves that stage. A load waits in the last stage until the load-data queue head matches its tag. Any other instruction waits there until the completion queue head matches its tag. While the last stage waits, every full stage above it holds. Empty stages keep filling, so bubbles close up.

Top module: `cp_retire_pipe`

## Requirements
- R1: After reset all stages are empty (`stage_full` = 0), `in_ready` is 1, all three push-ready outputs are 1 and no retire, store or drop pulse is present.
- R2: An instruction accepted at a clock edge with no stall is in the first stage during the following cycle. A non-store reaches the last stage five cycles later. Instructions retire in the order they were accepted, with their tag and instruction word unchanged.
- R3: While the last stage waits for a token, every full stage holds its contents. `in_ready` is 0 only when all six stages are full. Empty stages below a new entry still accept it. Once tokens arrive in order, a full pipeline retires one instruction per cycle.
- R4: When the first stage is full and the kill queue head equals its tag, `drop_valid` pulses with that tag, the instruction disappears without retiring and the token is popped. A kill token with any other tag is kept and not consumed.
- R5: Class 2'b10 (store) pulses `st_valid` with its tag and word in the cycle it sits in the first stage, even if later stages are stalled. It never occupies stages two to six. A killed store gives only a drop pulse.
- R6: Class 2'b01 (load) in the last stage retires only when the load-data queue head equals its tag. That entry is then popped, so a second load with the same tag waits for a new entry.
- R7: Classes 2'b00 and 2'b11 (data processing) in the last stage retire only when the completion queue head equals its tag. That token is then popped.
- R8: A queue head whose tag differs from the waiting instruction, or a token in the queue of the wrong class, is not consumed, and the instruction stays in the last stage.
- R9: Each queue holds QD tokens. Its push-ready output is 0 when it is full, and a push offered while it is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | First stage can take an instruction |
| in_class | input | 2 | 01 load, 10 store, 00/11 data processing |
| in_tag | input | TW | Instruction tag |
| in_instr | input | IW | Decoded instruction word |
| cx_push_valid | input | 1 | Kill token offered |
| cx_push_tag | input | TW | Kill token tag |
| cx_push_ready | output | 1 | Kill queue has room |
| fin_push_valid | input | 1 | Completion token offered |
| fin_push_tag | input | TW | Completion token tag |
| fin_push_ready | output | 1 | Completion queue has room |
| ld_push_valid | input | 1 | Load-data token offered |
| ld_push_tag | input | TW | Load-data token tag |
| ld_push_ready | output | 1 | Load-data queue has room |
| ret_valid | output | 1 | Last stage retires this cycle |
| ret_tag | output | TW | Tag of retiring instruction |
| ret_instr | output | IW | Word of retiring instruction |
| ret_is_load | output | 1 | Retiring instruction is a load |
| st_valid | output | 1 | Store retires from first stage |
| st_tag | output | TW | Store tag |
| st_instr | output | IW | Store word |
| drop_valid | output | 1 | First-stage instruction killed |
| drop_tag | output | TW | Killed tag |
| stage_full | output | NS | Occupancy, bit 0 first stage |

## Verification
A corrupted occupancy bit or a wrong enable shows at `stage_full` and `in_ready` in the next cycle. It also shows as a retire pulse that comes one or more cycles early or late, compared with the accept-cycle-plus-five rule. A token popped at the wrong time shows only later, when a following instruction with the same tag either retires without a fresh token or hangs. So the bench reuses tags and watches for tens of cycles. Tag or word corruption in a stage shows on the retire, store or drop outputs when that instruction leaves.

// File: rtl/cp_retire_pipe.sv
module cp_retire_pipe #(
  parameter int TW = 4,
  parameter int IW = 16,
  parameter int NS = 6,
  parameter int QD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_class,
  input  logic [TW-1:0] in_tag,
  input  logic [IW-1:0] in_instr,
  input  logic          cx_push_valid,
  input  logic [TW-1:0] cx_push_tag,
  output logic          cx_push_ready,
  input  logic          fin_push_valid,
  input  logic [TW-1:0] fin_push_tag,
  output logic          fin_push_ready,
  input  logic          ld_push_valid,
  input  logic [TW-1:0] ld_push_tag,
  output logic          ld_push_ready,
  output logic          ret_valid,
  output logic [TW-1:0] ret_tag,
  output logic [IW-1:0] ret_instr,
  output logic          ret_is_load,
  output logic          st_valid,
  output logic [TW-1:0] st_tag,
  output logic [IW-1:0] st_instr,
  output logic          drop_valid,
  output logic [TW-1:0] drop_tag,
  output logic [NS-1:0] stage_full
);
  localparam int PW = (QD > 1) ? $clog2(QD) : 1;
  localparam int CW = $clog2(QD) + 1;
  localparam logic [1:0] C_LD = 2'b01;
  localparam logic [1:0] C_ST = 2'b10;
  localparam int QX = 0;
  localparam int QF = 1;
  localparam int QL = 2;
  localparam int LS = NS - 1;

  logic [2:0]    pv, pr, hv, pop;
  logic [TW-1:0] pt [3];
  logic [TW-1:0] ht [3];

  assign pv    = {ld_push_valid, fin_push_valid, cx_push_valid};
  assign pt[QX] = cx_push_tag;
  assign pt[QF] = fin_push_tag;
  assign pt[QL] = ld_push_tag;
  assign cx_push_ready  = pr[QX];
  assign fin_push_ready = pr[QF];
  assign ld_push_ready  = pr[QL];

  for (genvar q = 0; q < 3; q++) begin : g_q
    logic [TW-1:0] mem [QD];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          psh;

    assign psh   = pv[q] && pr[q];
    assign pr[q] = cnt != CW'(QD);
    assign hv[q] = cnt != '0;
    assign ht[q] = mem[rp];

    always_ff @(posedge clk)
      if (psh) mem[wp] <= pt[q];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (psh)    wp <= (wp == PW'(QD - 1)) ? '0 : wp + 1'b1;
        if (pop[q]) rp <= (rp == PW'(QD - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(psh) - CW'(pop[q]);
      end

    p_q_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(QD));
    p_q_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(QD) && !pop[q]) |=> cnt == CW'(QD));
  end

  logic [NS-1:0] full, en;
  logic [NS-2:0] adv;
  logic [TW-1:0] tag_q [NS];
  logic [IW-1:0] ins_q [NS];
  logic [1:0]    cls_q [NS];
  logic          cx_hit, st0, ld6, ret6;

  assign st0    = cls_q[0] == C_ST;
  assign ld6    = cls_q[LS] == C_LD;
  assign cx_hit = full[0] && hv[QX] && ht[QX] == tag_q[0];
  assign ret6   = full[LS] && (ld6 ? (hv[QL] && ht[QL] == tag_q[LS])
                                   : (hv[QF] && ht[QF] == tag_q[LS]));

  assign pop[QX] = cx_hit;
  assign pop[QF] = ret6 && !ld6;
  assign pop[QL] = ret6 && ld6;

  always_comb begin
    logic acc;
    acc = ret6;
    for (int i = LS; i >= 1; i--) begin
      acc   = acc | !full[i];
      en[i] = acc;
    end
    en[0]  = !full[0] || cx_hit || st0 || en[1];
    adv[0] = full[0] && !cx_hit && !st0 && en[1];
    for (int i = 1; i < LS; i++) adv[i] = full[i] && en[i+1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      full <= '0;
      for (int i = 0; i < NS; i++) begin
        tag_q[i] <= '0;
        ins_q[i] <= '0;
        cls_q[i] <= '0;
      end
    end else begin
      if (en[0]) begin
        full[0]  <= in_valid;
        tag_q[0] <= in_tag;
        ins_q[0] <= in_instr;
        cls_q[0] <= in_class;
      end
      for (int i = 1; i < NS; i++)
        if (en[i]) begin
          full[i]  <= adv[i-1];
          tag_q[i] <= tag_q[i-1];
          ins_q[i] <= ins_q[i-1];
          cls_q[i] <= cls_q[i-1];
        end
    end

  assign in_ready    = en[0];
  assign stage_full  = full;
  assign ret_valid   = ret6;
  assign ret_tag     = tag_q[LS];
  assign ret_instr   = ins_q[LS];
  assign ret_is_load = ld6;
  assign st_valid    = full[0] && st0 && !cx_hit;
  assign st_tag      = tag_q[0];
  assign st_instr    = ins_q[0];
  assign drop_valid  = cx_hit;
  assign drop_tag    = tag_q[0];

  p_busy_only_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> &full);
  p_hold_while_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full[LS] && !ret_valid) |=> (full[LS] && $stable(tag_q[LS])));
  p_store_shallow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full[1] |-> cls_q[1] != C_ST);
  p_drop_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_valid && !in_valid) |=> !full[0]);
  p_retire_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !full[LS-1]) |=> !full[LS]);
endmodule

// File: tb/cp_retire_pipe_tb_top.sv
module cp_retire_pipe_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic       in_valid = 0, in_ready;
  logic [1:0] in_class = 0;
  logic [3:0] in_tag = 0;
  logic [15:0] in_instr = 0;
  logic       cx_push_valid = 0, fin_push_valid = 0, ld_push_valid = 0;
  logic [3:0] cx_push_tag = 0, fin_push_tag = 0, ld_push_tag = 0;
  logic       cx_push_ready, fin_push_ready, ld_push_ready;
  logic       ret_valid, ret_is_load, st_valid, drop_valid;
  logic [3:0] ret_tag, st_tag, drop_tag;
  logic [15:0] ret_instr, st_instr;
  logic [5:0] stage_full;

  cp_retire_pipe #(.TW(4), .IW(16), .NS(6), .QD(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_class(in_class),
    .in_tag(in_tag), .in_instr(in_instr),
    .cx_push_valid(cx_push_valid), .cx_push_tag(cx_push_tag), .cx_push_ready(cx_push_ready),
    .fin_push_valid(fin_push_valid), .fin_push_tag(fin_push_tag), .fin_push_ready(fin_push_ready),
    .ld_push_valid(ld_push_valid), .ld_push_tag(ld_push_tag), .ld_push_ready(ld_push_ready),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_instr(ret_instr), .ret_is_load(ret_is_load),
    .st_valid(st_valid), .st_tag(st_tag), .st_instr(st_instr),
    .drop_valid(drop_valid), .drop_tag(drop_tag), .stage_full(stage_full));

  int cyc = 0;
  int total = 0;
  int fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ev_kind [256];
  int ev_tag  [256];
  int ev_ins  [256];
  int ev_cyc  [256];
  int n_ev = 0;

  always @(negedge clk) if (rst_n) begin
    if (st_valid)   begin ev_kind[n_ev] = 1; ev_tag[n_ev] = st_tag;   ev_ins[n_ev] = st_instr;  ev_cyc[n_ev] = cyc; n_ev++; end
    if (drop_valid) begin ev_kind[n_ev] = 2; ev_tag[n_ev] = drop_tag; ev_ins[n_ev] = 0;         ev_cyc[n_ev] = cyc; n_ev++; end
    if (ret_valid)  begin ev_kind[n_ev] = 0; ev_tag[n_ev] = ret_tag;  ev_ins[n_ev] = ret_instr; ev_cyc[n_ev] = cyc; n_ev++; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    in_valid = 0; cx_push_valid = 0; fin_push_valid = 0; ld_push_valid = 0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    n_ev = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] word(input logic [1:0] c, input logic [3:0] t);
    return 16'hA000 | (16'(c) << 8) | 16'(t) | (16'(t) << 4);
  endfunction

  task automatic issue(input logic [1:0] c, input logic [3:0] t, output int acc);
    in_valid = 1; in_class = c; in_tag = t; in_instr = word(c, t);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 acc = cyc;
    in_valid = 0;
  endtask

  task automatic push(input int sel, input logic [3:0] t);
    if (sel == 0) begin cx_push_valid = 1; cx_push_tag = t; end
    else if (sel == 1) begin fin_push_valid = 1; fin_push_tag = t; end
    else begin ld_push_valid = 1; ld_push_tag = t; end
    @(negedge clk);
    while ((sel == 0 && !cx_push_ready) || (sel == 1 && !fin_push_ready) ||
           (sel == 2 && !ld_push_ready)) @(negedge clk);
    @(posedge clk);
    #1 cx_push_valid = 0; fin_push_valid = 0; ld_push_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  [TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

  initial begin
    int acc, n0, acc2;
    do_reset();
    @(negedge clk);
    // R1 reset state
    check(stage_full == 0, "R1 occupancy", stage_full, 0);
    check(in_ready == 1, "R1 in_ready", in_ready, 1);
    check({cx_push_ready, fin_push_ready, ld_push_ready} == 3'b111, "R1 push ready",
          {cx_push_ready, fin_push_ready, ld_push_ready}, 7);
    check({ret_valid, st_valid, drop_valid} == 0, "R1 no pulses",
          {ret_valid, st_valid, drop_valid}, 0);
    @(posedge clk); #1;

    // Sweep: every class and tag (R2 R5 R6 R7)
    for (int c = 0; c < 4; c++)
      for (int t = 0; t < 16; t++) begin
        n0 = n_ev;
        if (c == 1) push(2, 4'(t));
        else if (c != 2) push(1, 4'(t));
        issue(2'(c), 4'(t), acc);
        idle(8);
        check(n_ev == n0 + 1, "R2 one event per instr", n_ev - n0, 1);
        if (c == 2) begin
          check(ev_kind[n0] == 1 && ev_cyc[n0] == acc, "R5 store leaves at stage one",
                ev_cyc[n0] - acc, 0);
        end else begin
          check(ev_kind[n0] == 0 && ev_cyc[n0] == acc + 5, "R2 latency to retire",
                ev_cyc[n0] - acc, 5);
        end
        check(ev_tag[n0] == t && ev_ins[n0] == int'(word(2'(c), 4'(t))), "R2 tag and word",
              ev_ins[n0], int'(word(2'(c), 4'(t))));
        check(stage_full == 0, "R5 R7 pipe empty afterwards", stage_full, 0);
      end

    // R6 load token consumed
    do_reset();
    push(2, 4'd5);
    issue(2'b01, 4'd5, acc);
    idle(7);
    check(n_ev == 1 && ev_cyc[0] == acc + 5, "R6 load retires", n_ev, 1);
    issue(2'b01, 4'd5, acc);
    idle(15);
    check(n_ev == 1, "R6 token popped, second load waits", n_ev, 1);
    check(stage_full == 6'h20, "R6 load held in last stage", stage_full, 32);
    push(2, 4'd5);
    idle(2);
    check(n_ev == 2 && ev_tag[1] == 5, "R6 fresh token retires load", n_ev, 2);

    // R8 mismatch and wrong queue
    do_reset();
    issue(2'b00, 4'd2, acc);
    push(1, 4'd4);
    push(2, 4'd2);
    idle(12);
    check(n_ev == 0, "R8 no retire on mismatch", n_ev, 0);
    check(stage_full == 6'h20, "R8 instr stays in last stage", stage_full, 32);

    // R3 full pipe stall then in-order drain
    do_reset();
    for (int t = 0; t < 6; t++) issue(2'b00, 4'(t), acc);
    idle(4);
    @(negedge clk);
    check(stage_full == 6'h3F, "R3 all stages full", stage_full, 63);
    check(in_ready == 0, "R3 in_ready low when full", in_ready, 0);
    @(posedge clk); #1;
    for (int t = 0; t < 6; t++) push(1, 4'(t));
    idle(3);
    check(n_ev == 6, "R3 all retire", n_ev, 6);
    for (int k = 0; k < 6; k++)
      check(ev_tag[k] == k, "R3 retire order", ev_tag[k], k);
    for (int k = 1; k < 6; k++)
      check(ev_cyc[k] == ev_cyc[k-1] + 1, "R3 one per cycle", ev_cyc[k] - ev_cyc[k-1], 1);

    // R3 bubble collapse and R5 store past a stall
    do_reset();
    issue(2'b00, 4'd1, acc);
    idle(6);
    issue(2'b10, 4'd3, acc2);
    idle(1);
    check(n_ev == 1 && ev_kind[0] == 1 && ev_cyc[0] == acc2, "R5 store retires during stall",
          n_ev, 1);
    issue(2'b00, 4'd2, acc);
    idle(8);
    @(negedge clk);
    check(stage_full == 6'h30, "R3 empty stages fill", stage_full, 48);
    check(in_ready == 1, "R3 in_ready with room", in_ready, 1);
    @(posedge clk); #1;
    push(1, 4'd1);
    push(1, 4'd2);
    idle(2);
    check(n_ev == 3 && ev_tag[1] == 1 && ev_tag[2] == 2, "R3 drain after bubble", n_ev, 3);

    // R4 cancel matching and mismatching
    do_reset();
    push(0, 4'd6);
    issue(2'b00, 4'd6, acc);
    idle(8);
    check(n_ev == 1 && ev_kind[0] == 2 && ev_cyc[0] == acc && ev_tag[0] == 6,
          "R4 drop in stage one", ev_kind[0], 2);
    check(stage_full == 0, "R4 dropped instr gone", stage_full, 0);
    do_reset();
    push(0, 4'd9);
    push(1, 4'd1);
    issue(2'b00, 4'd1, acc);
    idle(7);
    check(n_ev == 1 && ev_kind[0] == 0 && ev_cyc[0] == acc + 5, "R4 mismatch kill ignored",
          ev_kind[0], 0);
    issue(2'b00, 4'd9, acc);
    idle(2);
    check(n_ev == 2 && ev_kind[1] == 2 && ev_tag[1] == 9, "R4 held kill token used later",
          ev_kind[1], 2);
    push(0, 4'd11);
    issue(2'b10, 4'd11, acc);
    idle(3);
    check(n_ev == 3 && ev_kind[2] == 2, "R5 R4 killed store only drops", ev_kind[2], 2);

    // R9 queue full, extra push ignored
    do_reset();
    for (int t = 1; t <= 4; t++) push(1, 4'(t));
    @(negedge clk);
    check(fin_push_ready == 0, "R9 push ready low when full", fin_push_ready, 0);
    @(posedge clk); #1;
    fin_push_valid = 1; fin_push_tag = 4'd9;
    @(posedge clk); #1 fin_push_valid = 0;
    for (int t = 1; t <= 4; t++) issue(2'b00, 4'(t), acc);
    issue(2'b00, 4'd9, acc);
    idle(20);
    check(n_ev == 4, "R9 dropped push not stored", n_ev, 4);
    check(stage_full == 6'h20, "R9 last instr waits", stage_full, 32);
    push(1, 4'd9);
    idle(2);
    check(n_ev == 5 && ev_tag[4] == 9, "R9 later push accepted", n_ev, 5);

    $display("  [TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end
endmodule